// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 131,072 words by 24 bits. It turns each accepted single-word request into a timed strobe sequence on the memory pins. A request is a valid/ready handshake carrying a write flag, a 17-bit address and 24-bit write data. A read returns its word on a data output, marked by a one-cycle valid pulse. Every strobe width and gap is a parameter counted in clock cycles, so the same logic can follow the memory's nanosecond minimums at any clock rate.

On the memory side the controller drives the address, three chip selects of mixed polarity, an output enable and a write enable. It also drives a 24-bit data output together with a drive-enable for the pad buffer outside the block. It samples a 24-bit data input. Writes are ended by the write enable, with the output enable held inactive. The controller drives the data bus only when the memory cannot be driving it. Between accesses the memory is deselected, which puts it in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: The memory counts as selected only when sel_a_n=0, sel_b=1 and sel_c_n=0. Outside an access, including reset, idle and the post-read gap, the three pins rest at sel_a_n=1, sel_b=0 and sel_c_n=1. No other combination ever appears.
- R2: A read holds oe_n low for exactly RD_CYC consecutive cycles, with we_n high. The word on mem_din is captured at the clock edge that ends the last oe_n-low cycle. rd_valid is high for exactly one cycle, 2+RD_CYC cycles after the request is accepted, and oe_n is already high in that cycle.
- R3: A write holds we_n low for exactly WE_CYC consecutive cycles, with oe_n high for the whole write. oe_n and we_n are never low together.
- R4: During a write, mem_drive turns on DRV_DLY cycles after we_n falls, stays on through the cycle in which we_n returns high, and turns off afterwards. The data presented is the request's write data.
- R5: mem_drive is never high while oe_n is low, nor in the cycle right after oe_n returns high.
- R6: req_ready is high only when idle. A write occupies the controller for 3+WE_CYC cycles, and a read for 3+RD_CYC+TURN_CYC cycles, the last TURN_CYC of which are deselected. A request held on the port while the controller is busy has no effect until req_ready returns.
- R7: After reset, the selects are at their idle levels, oe_n=1, we_n=1, mem_drive=0, req_ready=1 and rd_valid=0.
- R8: mem_addr and mem_dout hold the values latched at acceptance for the whole access, whatever the request inputs do meanwhile.
- R9: A read returns the word most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-cycle pulse, rd_data valid |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_sel_a_n | output | 1 | Active-low select A |
| mem_sel_b | output | 1 | Active-high select B |
| mem_sel_c_n | output | 1 | Active-low select C |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | DATA_W | Data toward the memory |
| mem_drive | output | 1 | Enable for the data pad driver |
| mem_din | input | DATA_W | Data from the memory |

## Verification
The hardest cases are a request held on the port while a read is still in flight, and a memory that is still driving when the controller might start to drive. The bench holds a write to another address on the port through every cycle of a read and withdraws it at the negative edge where req_ready returns. Reading that address later shows whether the write leaked through. The bench's memory model returns wrong data until oe_n has been low for RD_CYC whole cycles, and it keeps claiming the bus for one cycle after oe_n rises. An early capture or an early drive therefore shows up at the ports.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURN
  } acc_state_e;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt_next,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (load)              cnt_next = load_val;
    else if (cnt_q != '0)  cnt_next = cnt_q - 1'b1;
    else                   cnt_next = '0;
  end

  assign done = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end
endmodule

// File: rtl/sram_access_fsm.sv
module sram_access_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int WE_CYC   = 1,
  parameter int TURN_CYC = 1,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_done,
  output acc_state_e    state_q,
  output acc_state_e    state_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture
);
  localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WE_LOAD = CW'(WE_CYC - 1);
  localparam logic [CW-1:0] TN_LOAD = CW'(TURN_CYC - 1);

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_RD_WAIT) && tmr_done;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE:       if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
      ST_RD_SETUP: begin
        state_d  = ST_RD_WAIT;
        tmr_load = 1'b1;
        tmr_val  = RD_LOAD;
      end
      ST_RD_WAIT:    if (tmr_done) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = TN_LOAD;
      end
      ST_TURN:       if (tmr_done) state_d = ST_IDLE;
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = WE_LOAD;
      end
      ST_WR_PULSE:   if (tmr_done) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 24,
  parameter int WE_CYC  = 1,
  parameter int DRV_DLY = 0,
  parameter int CW      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_state_e        state_d,
  input  logic [CW-1:0]     cnt_d,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              sel_a_n,
  output logic              sel_b,
  output logic              sel_c_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dout,
  output logic              drive,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ready
);
  localparam logic [CW-1:0] DRV_LIMIT = CW'(WE_CYC - 1 - DRV_DLY);

  logic sel_d, oe_n_d, we_n_d, drive_d;

  always_comb begin
    sel_d   = !(state_d == ST_IDLE || state_d == ST_TURN);
    oe_n_d  = !(state_d == ST_RD_WAIT);
    we_n_d  = !(state_d == ST_WR_PULSE);
    drive_d = ((state_d == ST_WR_PULSE) && (cnt_d <= DRV_LIMIT)) ||
              (state_d == ST_WR_RECOVER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_a_n  <= 1'b1;
      sel_b    <= 1'b0;
      sel_c_n  <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      drive    <= 1'b0;
      rd_valid <= 1'b0;
      ready    <= 1'b1;
      mem_addr <= '0;
      dout     <= '0;
      rd_data  <= '0;
    end else begin
      sel_a_n  <= !sel_d;
      sel_b    <= sel_d;
      sel_c_n  <= !sel_d;
      oe_n     <= oe_n_d;
      we_n     <= we_n_d;
      drive    <= drive_d;
      rd_valid <= capture;
      ready    <= (state_d == ST_IDLE);
      if (accept) begin
        mem_addr <= req_addr;
        dout     <= req_wdata;
      end
      if (capture) rd_data <= mem_din;
    end
  end

  AST_SEL_COHERENT: assert property (@(posedge clk) disable iff (rst)
    (sel_a_n == sel_c_n) && (sel_b != sel_a_n)); // R1
  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    ready |-> (sel_a_n && !sel_b)); // R1
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n)); // R3
  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R2
  AST_RDV_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (oe_n && $past(!oe_n))); // R2
  AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> drive); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    drive |-> (oe_n && $past(oe_n))); // R5
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
    $past(rd_valid) |-> (sel_a_n && !drive)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!sel_a_n && $past(!sel_a_n)) |-> $stable(mem_addr)); // R8
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 24,
  parameter int RD_CYC   = 2,
  parameter int WE_CYC   = 1,
  parameter int DRV_DLY  = 0,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_a_n,
  output logic              mem_sel_b,
  output logic              mem_sel_c_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_drive,
  input  logic [DATA_W-1:0] mem_din
);
  localparam int MAX_RW = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int MAX_C  = (MAX_RW > TURN_CYC) ? MAX_RW : TURN_CYC;
  localparam int CW     = $clog2(MAX_C + 1) + 1;

  acc_state_e    state_q, state_d;
  logic          tmr_load, tmr_done, accept, capture;
  logic [CW-1:0] tmr_val, cnt_d;

  sram_access_fsm #(
    .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC), .CW(CW)
  ) fsm_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .tmr_done(tmr_done), .state_q(state_q), .state_d(state_d),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept), .capture(capture)
  );

  sram_phase_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .cnt_next(cnt_d), .done(tmr_done)
  );

  sram_pin_stage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_CYC(WE_CYC), .DRV_DLY(DRV_DLY), .CW(CW)
  ) pins_i (
    .clk(clk), .rst(rst), .state_d(state_d), .cnt_d(cnt_d), .accept(accept),
    .capture(capture), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_din(mem_din), .mem_addr(mem_addr), .sel_a_n(mem_sel_a_n),
    .sel_b(mem_sel_b), .sel_c_n(mem_sel_c_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .dout(mem_dout), .drive(mem_drive), .rd_data(rd_data), .rd_valid(rd_valid),
    .ready(req_ready)
  );
endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
  localparam int AW = 17, DW = 24, RD_CYC = 2, WE_CYC = 1, DRV_DLY = 0, TURN_CYC = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, sel_a_n, sel_b, sel_c_n, oe_n, we_n, drive;
  logic [DW-1:0] rd_data, dout, din;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  int sel_err = 0, oe_err = 0, we_err = 0, wr_err = 0, cont_err = 0, addr_err = 0;

  always #10 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC),
                    .DRV_DLY(DRV_DLY), .TURN_CYC(TURN_CYC)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_sel_a_n(sel_a_n), .mem_sel_b(sel_b), .mem_sel_c_n(sel_c_n),
    .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_dout(dout), .mem_drive(drive),
    .mem_din(din));

  // Memory model: 256 slots keyed by the low address byte, full address as tag.
  logic [AW-1:0] mtag [256];
  logic [DW-1:0] mdat [256];
  int oe_cnt = 0, we_run = 0, oe_run = 0;
  logic hold_bus = 1'b0, pend = 1'b0, pend_ok = 1'b0, prev_sel = 1'b0;
  logic [DW-1:0] pend_dat = '0;
  logic [AW-1:0] pend_adr = '0, prev_addr = '0;
  logic selected, mem_drv;
  logic [DW-1:0] slot_val;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign mem_drv  = selected && !oe_n && we_n;
  assign slot_val = (mtag[mem_addr[7:0]] == mem_addr) ? mdat[mem_addr[7:0]] : '0;
  assign din      = !mem_drv ? '0 : (oe_cnt >= RD_CYC ? slot_val : ~slot_val);

  initial for (int k = 0; k < 256; k++) begin mtag[k] = '1; mdat[k] = '0; end

  always @(negedge clk) if (!rst) begin
    if (!((!sel_a_n && sel_b && !sel_c_n) || (sel_a_n && !sel_b && sel_c_n))) sel_err++;
    if (req_ready && !sel_a_n) sel_err++;
    if (!oe_n && !we_n) we_err++;
    if (drive && (mem_drv || hold_bus)) cont_err++;
    if (selected && prev_sel && mem_addr != prev_addr) addr_err++;
    if (!we_n) we_run++;
    else begin if (we_run != 0 && we_run != WE_CYC) we_err++; we_run = 0; end
    if (!oe_n) oe_run++;
    else begin if (oe_run != 0 && oe_run != RD_CYC) oe_err++; oe_run = 0; end
    if (selected && !we_n) begin
      pend = 1'b1; pend_ok = drive; pend_dat = dout; pend_adr = mem_addr;
    end else if (pend) begin
      if (pend_ok && drive) begin mtag[pend_adr[7:0]] = pend_adr; mdat[pend_adr[7:0]] = pend_dat; end
      else wr_err++;
      pend = 1'b0;
    end
    oe_cnt    = (!oe_n && selected) ? oe_cnt + 1 : 0;
    hold_bus  = mem_drv;
    prev_sel  = selected;
    prev_addr = mem_addr;
  end

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [AW-1:0] addr_of(input int i);
    logic [31:0] t = 32'(i * 37 + 5);
    logic [31:0] u = 32'(i);
    return {t[8:0], u[7:0]};
  endfunction

  function automatic logic [DW-1:0] data_of(input int i, input int p);
    logic [31:0] t = 32'((i * 40503 + p * 11213 + 7) ^ (i << 9) ^ 32'h5A3C1);
    return t[DW-1:0];
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    @(negedge clk); while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; // R8 scramble
    n = 1;
    while (!req_ready && n < 40) begin @(negedge clk); n++; end
    chk("R6 write occupancy", n == 3 + WE_CYC, n, 3 + WE_CYC);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e,
                         input bit probe, input logic [AW-1:0] pa);
    int n;
    @(negedge clk); while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = probe; req_write = 1'b1; req_addr = pa; req_wdata = ~e; // R6 held request
    n = 1;
    while (!rd_valid && n < 40) begin @(negedge clk); n++; end
    chk("R2 read latency", n == 2 + RD_CYC, n, 2 + RD_CYC);
    chk("R9 read data", rd_data == e, rd_data, e);
    @(negedge clk); n++;
    chk("R2 valid pulse width", !rd_valid, rd_valid, 0);
    while (!req_ready && n < 40) begin @(negedge clk); n++; end
    req_valid = 1'b0;
    chk("R6 read occupancy", n == 3 + RD_CYC + TURN_CYC, n, 3 + RD_CYC + TURN_CYC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 reset selects", sel_a_n && !sel_b && sel_c_n, {sel_a_n, sel_b, sel_c_n}, 3'b101);
    chk("R7 reset strobes", oe_n && we_n, {oe_n, we_n}, 2'b11);
    chk("R7 reset drive", !drive, drive, 0);
    chk("R7 reset ready", req_ready && !rd_valid, {req_ready, rd_valid}, 2'b10);
    // Sweep 1: fill all slots, then read back with a held write probing the next slot.
    for (int i = 0; i < 256; i++) do_write(addr_of(i), data_of(i, 0));
    for (int i = 0; i < 256; i++)
      do_read(addr_of(i), data_of(i, 0), i[0] && i < 255, addr_of((i + 1) % 256));
    // Sweep 2: overwrite and read back immediately, back to back.
    for (int i = 0; i < 256; i++) begin
      do_write(addr_of(i), data_of(i, 1));
      do_read(addr_of(i), data_of(i, 1), 1'b0, '0);
    end
    // Sweep 3: read the neighbours again to catch writes landing at wrong addresses.
    for (int i = 0; i < 256; i += 5) do_read(addr_of(i), data_of(i, 1), 1'b0, '0);
    repeat (4) @(negedge clk);
    chk("R1 select encoding and idle deselect", sel_err == 0, sel_err, 0);
    chk("R2 oe low run length", oe_err == 0, oe_err, 0);
    chk("R3 we low run length and strobe exclusion", we_err == 0, we_err, 0);
    chk("R4 data driven through we rise", wr_err == 0, wr_err, 0);
    chk("R5 bus contention", cont_err == 0, cont_err, 0);
    chk("R8 address held during access", addr_err == 0, addr_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule